// File: doc/BRIEF.md
# Timed Four-Rail Power Sequencer

This controller brings four supply rails up and down in an order chosen by software-loaded delay values. It watches a system enable, four already-compared undervoltage-good flags and four flags that report each gate driver has reached full drive. It produces one gate-enable per rail, a fast-discharge control, and two active-low resets: one for normal power-good (`rst_pg_n`) and one that signals a supply fault (`rst_sys_n`).

All timing is counted in pulses of a clock-enable input `tick` that runs at a known rate. Start-up is held off until the enable and all four undervoltage-good flags have been true together for an unbroken qualification window. The four turn-on counters then start together, and each rail opens when its own counter reaches its delay. Once every gate reports full drive, a settle window runs before the power-good reset is released. Once all rails are on, an undervoltage lasting beyond a glitch window forces every gate off at once. Removing the enable instead closes the rails one at a time on their own turn-off delays. With the enable off and nothing running, the block rests in a sleep state in which every counter is held clear.

The control pins are plain levels with no handshake. The delay fields are static configuration and are sampled every cycle.

Top module: `rail_sequencer`

## Requirements
- R1: From sleep, an active enable starts qualification. Turn-on begins only after QUAL_TICKS consecutive ticks in which the enable is active and all four undervoltage-good flags are 1. Any break clears the count.
- R2: All turn-on counters start from zero together when qualification completes. Rail i's gate enable (bit i of `gate_en`) rises in the first cycle its counter equals field i of `on_dly` (bits 4i+3..4i at the bench width of 4). A delay of zero opens the rail in the first ramp cycle.
- R3: `rst_pg_n` stays 0 until all four gates are enabled and every `gate_full` bit is 1. It then rises after SETTLE_TICKS further ticks with `gate_full` all 1. A drop in `gate_full` during settling restarts that count.
- R4: Once all gates are enabled, a flag in `uv_ok` held at 0 for GLITCH_TICKS consecutive ticks is a fault.
- R5: In the cycle after a fault is detected, all gate enables are 0, `rst_pg_n` and `rst_sys_n` are 0, and `fast_dis` is 1. These values hold for as long as the fault state lasts.
- R6: Enable removal with no fault present drives `rst_pg_n` to 0 in the next cycle. All turn-off counters then start together, and each gate drops when its counter equals its field of `off_dly`.
- R7: During shutdown, a gate that has dropped never rises again. Shutdown runs to completion and returns to sleep even if the enable comes back.
- R8: While in sleep (`sleep_o`=1), all gates are 0 and `rst_pg_n` is 0. Undervoltage-good changes have no effect there.
- R9: When EN_ACTIVE_HIGH is 1, `en_in`=1 is the active enable level. When it is 0, `en_in`=0 is the active level. Every other behaviour is identical between the two settings.
- R10: The fault state holds while the enable stays active, even after undervoltage recovers. It is left only through enable removal (to sleep), followed by a full new qualification.
- R11: An undervoltage pulse shorter than GLITCH_TICKS ticks changes no output.
- R12: After reset: `sleep_o`=1, `gate_en`=0, `rst_pg_n`=0, `rst_sys_n`=1, `fast_dis`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase clock enable, one cycle per time unit |
| en_in | input | 1 | System enable; polarity set by EN_ACTIVE_HIGH |
| uv_ok | input | NCH | Per-rail undervoltage-good flags, 1 = rail above threshold |
| gate_full | input | NCH | Per-rail gate-at-full-drive flags |
| on_dly | input | NCH*DW | Per-rail turn-on delay in ticks, field i at bits DW*i+DW-1..DW*i |
| off_dly | input | NCH*DW | Per-rail turn-off delay in ticks, same field layout |
| gate_en | output | NCH | Per-rail gate enable |
| fast_dis | output | 1 | Fast discharge, high while in the fault state |
| rst_pg_n | output | 1 | Active-low power-good reset |
| rst_sys_n | output | 1 | Active-low system reset, low while in the fault state |
| sleep_o | output | 1 | High while idle in low-power sleep |

## Verification
The bench builds the block with QUAL_TICKS=6, SETTLE_TICKS=5, GLITCH_TICKS=3 and 4-bit delay fields, and it drives a tick on every other clock. These values make every window only a few dozen clocks long. A single run can therefore reach full turn-on, a filtered glitch, a latched fault with its enable-cycle exit, a shutdown that interrupts an unfinished ramp, and an enable return during shutdown. A second instance with EN_ACTIVE_HIGH=0 receives the inverted enable and must track the first in every cycle.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP  = 3'd0,
    ST_QUAL   = 3'd1,
    ST_RAMP   = 3'd2,
    ST_SETTLE = 3'd3,
    ST_RUN    = 3'd4,
    ST_SHUT   = 3'd5,
    ST_FAULT  = 3'd6
  } seq_state_e;
endpackage

// File: rtl/rseq_counter.sv
// Tick counter that saturates at a runtime limit; done while at the limit.
module rseq_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (clr)                   cnt <= '0;
    else if (step && cnt != limit)  cnt <= cnt + 1'b1;
  end

  assign done = (cnt == limit);
endmodule

// File: rtl/rseq_channel.sv
// One rail: turn-on and turn-off delay counters plus the gate decision.
module rseq_channel #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          on_clr,
  input  logic          on_step,
  input  logic          off_clr,
  input  logic          off_step,
  input  logic [DW-1:0] on_dly,
  input  logic [DW-1:0] off_dly,
  input  logic          live,
  input  logic          shutting,
  output logic          gate,
  output logic          on_done,
  output logic          off_done
);
  rseq_counter #(.W(DW)) u_on (
    .clk(clk), .rst_n(rst_n), .clr(on_clr), .step(on_step),
    .limit(on_dly), .done(on_done)
  );

  rseq_counter #(.W(DW)) u_off (
    .clk(clk), .rst_n(rst_n), .clr(off_clr), .step(off_step),
    .limit(off_dly), .done(off_done)
  );

  // The off counter holds at its limit, so a dropped gate stays dropped.
  assign gate = live && on_done && !(shutting && off_done);
endmodule

// File: rtl/rseq_fsm.sv
module rseq_fsm
  import rseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       qual_done,
  input  logic       all_on,
  input  logic       settle_done,
  input  logic       all_off,
  input  logic       fault,
  output seq_state_e state
);
  seq_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_SLEEP:  if (en) nxt = ST_QUAL;
      ST_QUAL: begin
        if (!en)            nxt = ST_SLEEP;
        else if (qual_done) nxt = ST_RAMP;
      end
      ST_RAMP: begin
        if (!en)            nxt = ST_SHUT;
        else if (all_on)    nxt = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (fault)            nxt = ST_FAULT;
        else if (!en)         nxt = ST_SHUT;
        else if (settle_done) nxt = ST_RUN;
      end
      ST_RUN: begin
        if (fault)          nxt = ST_FAULT;
        else if (!en)       nxt = ST_SHUT;
      end
      ST_SHUT:   if (all_off) nxt = ST_SLEEP;
      ST_FAULT:  if (!en)     nxt = ST_SLEEP;
      default:   nxt = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_SLEEP;
    else        state <= nxt;
  end
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import rseq_pkg::*;
#(
  parameter int NCH          = 4,
  parameter int DW           = 4,
  parameter int QUAL_TICKS   = 1000,
  parameter int SETTLE_TICKS = 16000,
  parameter int GLITCH_TICKS = 3,
  parameter bit EN_ACTIVE_HIGH = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en_in,
  input  logic [NCH-1:0]    uv_ok,
  input  logic [NCH-1:0]    gate_full,
  input  logic [NCH*DW-1:0] on_dly,
  input  logic [NCH*DW-1:0] off_dly,
  output logic [NCH-1:0]    gate_en,
  output logic              fast_dis,
  output logic              rst_pg_n,
  output logic              rst_sys_n,
  output logic              sleep_o
);
  localparam int QW = $clog2(QUAL_TICKS + 1);
  localparam int SW = $clog2(SETTLE_TICKS + 1);
  localparam int GW = $clog2(GLITCH_TICKS + 1);

  seq_state_e     state;
  logic           en;
  logic           qual_done, settle_done, fault;
  logic [NCH-1:0] on_done, off_done, uv_done;
  logic           live, shutting, armed, on_clr;

  assign en       = EN_ACTIVE_HIGH ? en_in : !en_in;
  assign live     = state inside {ST_RAMP, ST_SETTLE, ST_RUN, ST_SHUT};
  assign shutting = (state == ST_SHUT);
  assign armed    = state inside {ST_SETTLE, ST_RUN};
  assign on_clr   = state inside {ST_SLEEP, ST_QUAL, ST_FAULT};
  assign fault    = |uv_done;

  rseq_counter #(.W(QW)) u_qual (
    .clk(clk), .rst_n(rst_n),
    .clr(state != ST_QUAL || !(en && (&uv_ok))),
    .step(tick), .limit(QW'(QUAL_TICKS)), .done(qual_done)
  );

  rseq_counter #(.W(SW)) u_settle (
    .clk(clk), .rst_n(rst_n),
    .clr(state != ST_SETTLE || !(&gate_full)),
    .step(tick), .limit(SW'(SETTLE_TICKS)), .done(settle_done)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_rail
    rseq_channel #(.DW(DW)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .on_clr(on_clr), .on_step(tick && state == ST_RAMP),
      .off_clr(!shutting), .off_step(tick && shutting),
      .on_dly(on_dly[i*DW +: DW]), .off_dly(off_dly[i*DW +: DW]),
      .live(live), .shutting(shutting),
      .gate(gate_en[i]), .on_done(on_done[i]), .off_done(off_done[i])
    );

    rseq_counter #(.W(GW)) u_uvf (
      .clk(clk), .rst_n(rst_n),
      .clr(!armed || uv_ok[i]),
      .step(tick), .limit(GW'(GLITCH_TICKS)), .done(uv_done[i])
    );
  end

  rseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en),
    .qual_done(qual_done), .all_on(&on_done), .settle_done(settle_done),
    .all_off(&off_done), .fault(fault), .state(state)
  );

  assign rst_pg_n  = (state == ST_RUN);
  assign rst_sys_n = (state != ST_FAULT);
  assign fast_dis  = (state == ST_FAULT);
  assign sleep_o   = (state == ST_SLEEP);
endmodule

// File: rtl/rseq_checker.sv
module rseq_checker
  import rseq_pkg::*;
#(
  parameter int NCH = 4,
  parameter bit EN_ACTIVE_HIGH = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en_in,
  input logic [NCH-1:0] gate_full,
  input logic [NCH-1:0] gate_en,
  input logic           fast_dis,
  input logic           rst_pg_n,
  input logic           rst_sys_n,
  input logic           sleep_o,
  input seq_state_e     state
);
  logic en_act;
  assign en_act = EN_ACTIVE_HIGH ? en_in : !en_in;

  assert_fault_outputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sys_n |-> (gate_en == '0 && fast_dis && !rst_pg_n));

  assert_pg_after_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pg_n) |-> $past(&gate_full));

  assert_sleep_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> (gate_en == '0 && !rst_pg_n));

  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_sys_n && en_act) |=> !rst_sys_n);

  assert_shut_no_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHUT && $past(state) == ST_SHUT) |-> ((gate_en & ~$past(gate_en)) == '0));

  assert_rise_in_ramp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_en & ~$past(gate_en)) != '0) |-> ($past(state) == ST_QUAL || $past(state) == ST_RAMP));
endmodule

bind rail_sequencer rseq_checker #(.NCH(NCH), .EN_ACTIVE_HIGH(EN_ACTIVE_HIGH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_in(en_in), .gate_full(gate_full),
  .gate_en(gate_en), .fast_dis(fast_dis), .rst_pg_n(rst_pg_n),
  .rst_sys_n(rst_sys_n), .sleep_o(sleep_o), .state(state)
);

// File: tb/tb_rail_sequencer.sv
`timescale 1ns/1ps
module tb_rail_sequencer;
  localparam int QT = 6, STL = 5, GL = 3;
  localparam int S_SLP = 0, S_QUAL = 1, S_RAMP = 2, S_SET = 3, S_RUN = 4, S_SHUT = 5, S_FLT = 6;

  logic clk = 0, rst_n = 0, tick = 0, en = 0;
  logic [3:0] uv = 4'hF, full = 4'h0;
  logic [15:0] ondly  = {4'd2, 4'd4, 4'd1, 4'd3};
  logic [15:0] offdly = {4'd0, 4'd1, 4'd2, 4'd3};
  logic [3:0] gate_a, gate_b;
  logic fd_a, pg_a, sys_a, slp_a, fd_b, pg_b, sys_b, slp_b;
  int checks = 0, errors = 0, cycles = 0;
  bit auto_full = 1, done = 0;

  always #2.5 clk = ~clk;

  rail_sequencer #(.QUAL_TICKS(QT), .SETTLE_TICKS(STL), .GLITCH_TICKS(GL), .EN_ACTIVE_HIGH(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en_in(en), .uv_ok(uv), .gate_full(full),
    .on_dly(ondly), .off_dly(offdly), .gate_en(gate_a), .fast_dis(fd_a),
    .rst_pg_n(pg_a), .rst_sys_n(sys_a), .sleep_o(slp_a));

  rail_sequencer #(.QUAL_TICKS(QT), .SETTLE_TICKS(STL), .GLITCH_TICKS(GL), .EN_ACTIVE_HIGH(1'b0)) dut_n (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en_in(!en), .uv_ok(uv), .gate_full(full),
    .on_dly(ondly), .off_dly(offdly), .gate_en(gate_b), .fast_dis(fd_b),
    .rst_pg_n(pg_b), .rst_sys_n(sys_b), .sleep_o(slp_b));

  // Behavioural reference: integer timers stepped per clock.
  int ms, mq, mset, ns;
  int mon[4], moff[4], muv[4];
  bit aon, aoff, flt;

  function automatic int fld(input logic [15:0] v, input int i);
    return int'(v[i*4 +: 4]);
  endfunction

  function automatic logic [3:0] m_gates();
    logic [3:0] g = '0;
    for (int i = 0; i < 4; i++)
      if (ms >= S_RAMP && ms <= S_SHUT && mon[i] == fld(ondly, i) &&
          !(ms == S_SHUT && moff[i] == fld(offdly, i))) g[i] = 1'b1;
    return g;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = S_SLP; mq = 0; mset = 0;
      for (int i = 0; i < 4; i++) begin mon[i] = 0; moff[i] = 0; muv[i] = 0; end
    end else begin
      aon = 1; aoff = 1; flt = 0;
      for (int i = 0; i < 4; i++) begin
        if (mon[i] != fld(ondly, i)) aon = 0;
        if (moff[i] != fld(offdly, i)) aoff = 0;
        if (muv[i] == GL) flt = 1;
      end
      ns = ms;
      case (ms)
        S_SLP:  if (en) ns = S_QUAL;
        S_QUAL: if (!en) ns = S_SLP; else if (mq == QT) ns = S_RAMP;
        S_RAMP: if (!en) ns = S_SHUT; else if (aon) ns = S_SET;
        S_SET:  if (flt) ns = S_FLT; else if (!en) ns = S_SHUT; else if (mset == STL) ns = S_RUN;
        S_RUN:  if (flt) ns = S_FLT; else if (!en) ns = S_SHUT;
        S_SHUT: if (aoff) ns = S_SLP;
        S_FLT:  if (!en) ns = S_SLP;
        default: ns = S_SLP;
      endcase
      for (int i = 0; i < 4; i++) begin
        if (ms == S_SLP || ms == S_QUAL || ms == S_FLT) mon[i] = 0;
        else if (ms == S_RAMP && tick && mon[i] != fld(ondly, i)) mon[i]++;
        if (ms != S_SHUT) moff[i] = 0;
        else if (tick && moff[i] != fld(offdly, i)) moff[i]++;
        if (!(ms == S_SET || ms == S_RUN) || uv[i]) muv[i] = 0;
        else if (tick && muv[i] != GL) muv[i]++;
      end
      if (ms != S_QUAL || !(en && &uv)) mq = 0; else if (tick && mq != QT) mq++;
      if (ms != S_SET || !(&full)) mset = 0; else if (tick && mset != STL) mset++;
      ms = ns;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(gate_a, m_gates(), "R2 R6 R7 R11 gate_en");
    chk(pg_a, ms == S_RUN, "R3 R6 rst_pg_n");
    chk(sys_a, ms != S_FLT, "R4 R5 R10 rst_sys_n");
    chk(fd_a, ms == S_FLT, "R5 fast_dis");
    chk(slp_a, ms == S_SLP, "R1 R8 sleep_o");
    chk({gate_b, fd_b, pg_b, sys_b, slp_b}, {gate_a, fd_a, pg_a, sys_a, slp_a}, "R9 polarity");
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare();
      tick = !tick;
      if (auto_full) full = gate_a;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(slp_a, 1, "R12 sleep"); chk(gate_a, 0, "R12 gates");
    chk(pg_a, 0, "R12 pg"); chk(sys_a, 1, "R12 sys"); chk(fd_a, 0, "R12 fd");
    // R8: undervoltage toggling while asleep
    uv = 4'h0; cyc(6); uv = 4'hF; cyc(4);
    chk(slp_a, 1, "R8 still asleep");
    // R1: qualification blocked, then broken, then completed
    en = 1; uv = 4'b1011; cyc(20);
    chk(gate_a, 0, "R1 no start with rail low");
    uv = 4'hF; cyc(6); uv = 4'b0111; cyc(2); uv = 4'hF; cyc(8);
    chk(gate_a, 0, "R1 count restarted");
    cyc(50);
    chk(gate_a, 4'hF, "R2 all on"); chk(pg_a, 1, "R3 released");
    // R11: short glitch
    uv = 4'b1011; cyc(3); uv = 4'hF; cyc(6);
    chk(pg_a, 1, "R11 glitch ignored");
    // R4/R5: sustained undervoltage
    uv = 4'b1101; cyc(10);
    chk(sys_a, 0, "R5 fault"); chk(gate_a, 0, "R5 gates off");
    uv = 4'hF; cyc(30);
    chk(sys_a, 0, "R10 fault held");
    en = 0; cyc(4);
    chk(slp_a, 1, "R10 exit to sleep");
    en = 1; cyc(70);
    chk(pg_a, 1, "R10 requalified");
    // R6/R7: graceful shutdown with enable returning midway
    en = 0; cyc(2);
    chk(pg_a, 0, "R6 pg low first");
    cyc(3); en = 1; cyc(30);
    // ramp interrupted by enable removal
    cyc(70); en = 0; cyc(40);
    en = 1; cyc(16); en = 0; cyc(40);
    chk(slp_a, 1, "R7 back in sleep");
    // zero on delays, gate_full withheld then released
    ondly = 16'h0000; auto_full = 0; full = 4'h0; en = 1; cyc(40);
    chk(pg_a, 0, "R3 held without full");
    full = 4'hF; cyc(20);
    chk(pg_a, 1, "R3 released after full");
    en = 0; cyc(20);
    finish_run();
  end
endmodule